// File: doc/BRIEF.md
# Triangular loop sequencer with dummy-iteration padding

This block drives the control side of a pipelined column orthogonalisation engine. The engine walks a triangular nested loop: an outer index `i` and an inner index `j` that sweeps from a start point up to the last column. When the inner sweep gets short, the engine's read-after-write latency would be violated. The sequencer then starts the inner sweep earlier, at a fixed floor that can be negative, so that every outer pass lasts at least the latency. Each pass therefore has a padded length, and the total number of iterations is a constant fixed when the block is built.

After a `start` pulse the block presents one signed index pair per cycle. It moves to the next pair only in cycles where `adv_en` is high. Along with each pair it gives decoded comparison flags. It also gives a write strobe and a packed slot index for the upper-triangular result store, which is filled row by row from row 0. After the last iteration, `done` pulses and the block idles.

Top module: `tri_loop_seq`

## Requirements
- R1: While `rst` is high and in the cycles after it until a start, `busy`, `done` and `r_wr` are 0.
- R2: A `start` pulse while idle makes `busy` 1 from the next cycle, with `i_idx` = -1, `j_idx` = 0 and `r_widx` = 0.
- R3: On an advance (busy and `adv_en`) with `j_idx` not equal to COLS-1, `j_idx` goes up by one and `i_idx` holds.
- R4: On an advance with `j_idx` = COLS-1, `i_idx` goes up by one. The next `j_idx` is the old `i_idx`+1 when COLS-RAW_LAT > old `i_idx`, and COLS-RAW_LAT otherwise, which may be negative.
- R5: Exactly TOTAL = COLS + COLS(COLS+1)/2 + D advances happen per run. D is (COLS-1)COLS/2 + (RAW_LAT-COLS)COLS when RAW_LAT > COLS, and RAW_LAT(RAW_LAT-1)/2 otherwise.
- R6: The flags are combinational on the current pair:
  - `f_j_eq_i` is j==i.
  - `f_j_eq_ip1` is j==i+1.
  - `f_i_pos` is i>0.
  - `f_i_neg` is i<0.
  - `f_j_nneg` is j>=0.
  - `f_upd` is (i>=0 and j>=i).
- R7: `r_wr` is 1 in an advance cycle exactly when j>=i+1 and i+1<COLS. `r_widx` counts from 0 and goes up by one after each strobe, so it ends at COLS(COLS+1)/2.
- R8: In a busy cycle with `adv_en` low, the pair is unchanged in the next cycle and `r_wr` is 0.
- R9: `done` is 1 for exactly one cycle, in the cycle after the final advance, with `busy` 0. The block then stays idle until the next `start`. A `start` while busy is ignored.
- R10: RAW_LAT below 1 or COLS below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| adv_en | input | 1 | Advance to the next pair this cycle |
| busy | output | 1 | A run is in progress; the pair is valid |
| i_idx | output | IW | Signed outer index |
| j_idx | output | IW | Signed inner index |
| f_j_eq_i | output | 1 | j == i |
| f_j_eq_ip1 | output | 1 | j == i+1 |
| f_i_pos | output | 1 | i > 0 |
| f_i_neg | output | 1 | i < 0 |
| f_j_nneg | output | 1 | j >= 0 |
| f_upd | output | 1 | i >= 0 and j >= i |
| r_wr | output | 1 | Upper-triangle write strobe |
| r_widx | output | RWW | Packed upper-triangle slot index |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The index pair and `r_widx` come from registers. They take a new value in the cycle after an advance edge. The flags and `r_wr` are combinational on that pair and `adv_en`, so they are due within the same cycle. `done` is due one cycle after the final advance.

The bench changes inputs on the falling edge and checks a moment later. Each check therefore sees the registered state left by the preceding rising edge, together with the decode for the inputs just applied. Stall, start-while-busy and the idle cycles after `done` are each checked in the cycle in which their effect, or its absence, is due.

// File: rtl/tri_loop_seq.sv
module tri_loop_seq #(
  parameter int COLS = 4,
  parameter int RAW_LAT = 2,
  localparam int VAR = COLS - RAW_LAT,
  localparam int NEG = (VAR < 0) ? -VAR : 1,
  localparam int MAG = (COLS + 1 > NEG) ? COLS + 1 : NEG,
  localparam int IW = $clog2(MAG + 1) + 1,
  localparam int RSIZE = COLS * (COLS + 1) / 2,
  localparam int RWW = $clog2(RSIZE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  adv_en,
  output logic                  busy,
  output logic signed [IW-1:0]  i_idx,
  output logic signed [IW-1:0]  j_idx,
  output logic                  f_j_eq_i,
  output logic                  f_j_eq_ip1,
  output logic                  f_i_pos,
  output logic                  f_i_neg,
  output logic                  f_j_nneg,
  output logic                  f_upd,
  output logic                  r_wr,
  output logic [RWW-1:0]        r_widx,
  output logic                  done
);
  localparam int DUMMY = (RAW_LAT > COLS) ? (COLS - 1) * COLS / 2 + (RAW_LAT - COLS) * COLS
                                          : RAW_LAT * (RAW_LAT - 1) / 2;
  localparam int TOTAL = COLS + RSIZE + DUMMY;
  localparam int CW = $clog2(TOTAL + 1);
  localparam logic signed [IW-1:0] ZERO = '0;
  localparam logic signed [IW-1:0] ONE  = IW'(1);
  localparam logic signed [IW-1:0] MONE = -IW'(1);
  localparam logic signed [IW-1:0] LAST = IW'(COLS - 1);
  localparam logic signed [IW-1:0] NCOL = IW'(COLS);
  localparam logic signed [IW-1:0] FLOOR = IW'(VAR);
  localparam logic signed [IW-1:0] JMIN = (VAR < 0) ? IW'(VAR) : IW'(0);

  if (RAW_LAT < 1) begin : g_bad_lat
    $error("tri_loop_seq: RAW_LAT must be at least 1"); // R10
  end
  if (COLS < 2) begin : g_bad_cols
    $error("tri_loop_seq: COLS must be at least 2"); // R10
  end

  logic [CW-1:0] cnt;
  logic signed [IW-1:0] i_p1;
  logic step, wrap, last_step;

  assign i_p1      = i_idx + ONE;
  assign step      = busy && adv_en;
  assign wrap      = (j_idx == LAST);
  assign last_step = step && (cnt == CW'(TOTAL - 1));

  assign f_j_eq_i   = (j_idx == i_idx);
  assign f_j_eq_ip1 = (j_idx == i_p1);
  assign f_i_pos    = (i_idx > ZERO);
  assign f_i_neg    = (i_idx < ZERO);
  assign f_j_nneg   = (j_idx >= ZERO);
  assign f_upd      = (i_idx >= ZERO) && (j_idx >= i_idx);
  assign r_wr       = step && (j_idx >= i_p1) && (i_p1 < NCOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      i_idx  <= MONE;
      j_idx  <= ZERO;
      cnt    <= '0;
      r_widx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          i_idx  <= MONE;
          j_idx  <= ZERO;
          cnt    <= '0;
          r_widx <= '0;
        end
      end else if (step) begin
        cnt <= cnt + CW'(1);
        if (r_wr) r_widx <= r_widx + RWW'(1);
        if (wrap) begin
          i_idx <= i_p1;
          j_idx <= (FLOOR > i_idx) ? i_p1 : FLOOR;
        end else begin
          j_idx <= j_idx + ONE;
        end
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy && !adv_en |=> $stable(i_idx) && $stable(j_idx)); // R8
  AST_J_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (j_idx >= JMIN) && (j_idx <= LAST)); // R4
  AST_WIDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    r_wr |-> r_widx < RWW'(RSIZE)); // R7
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
    done |-> (r_widx == RWW'(RSIZE)) && !busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !r_wr); // R1
endmodule

// File: tb/test_tri_loop_seq.sv
module test_tri_loop_seq;
  localparam int PERIOD = 10;
  localparam int IW = 4;
  localparam int RWW = 4;
  localparam int N1 = 15;
  localparam int EXP_I [N1] = '{-1,-1,-1,-1, 0,0,0,0, 1,1,1, 2,2, 3,3};
  localparam int EXP_J [N1] = '{ 0, 1, 2, 3, 0,1,2,3, 1,2,3, 2,3, 2,3};

  logic clk = 0, rst = 1, start = 0, adv_en = 0, start2 = 0, adv2 = 0;
  logic busy, fa, fb, fc, fd, fe, ff, r_wr, done;
  logic signed [IW-1:0] i_idx, j_idx;
  logic [RWW-1:0] r_widx;
  logic busy2, ga, gb, gc, gd, ge, gf, r_wr2, done2;
  logic signed [IW-1:0] i2, j2;
  logic [RWW-1:0] widx2;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  tri_loop_seq #(.COLS(4), .RAW_LAT(2)) i_tri_loop_seq (
    .clk(clk), .rst(rst), .start(start), .adv_en(adv_en), .busy(busy),
    .i_idx(i_idx), .j_idx(j_idx), .f_j_eq_i(fa), .f_j_eq_ip1(fb), .f_i_pos(fc),
    .f_i_neg(fd), .f_j_nneg(fe), .f_upd(ff), .r_wr(r_wr), .r_widx(r_widx), .done(done));

  tri_loop_seq #(.COLS(4), .RAW_LAT(6)) i_tri_loop_seq_pad (
    .clk(clk), .rst(rst), .start(start2), .adv_en(adv2), .busy(busy2),
    .i_idx(i2), .j_idx(j2), .f_j_eq_i(ga), .f_j_eq_ip1(gb), .f_i_pos(gc),
    .f_i_neg(gd), .f_j_nneg(ge), .f_upd(gf), .r_wr(r_wr2), .r_widx(widx2), .done(done2));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input int ei, input int ej,
                           input logic a, b, c, d, e, f);
    chk({tag, " R6 j==i"},    a, int'(ej == ei));
    chk({tag, " R6 j==i+1"},  b, int'(ej == ei + 1));
    chk({tag, " R6 i>0"},     c, int'(ei > 0));
    chk({tag, " R6 i<0"},     d, int'(ei < 0));
    chk({tag, " R6 j>=0"},    e, int'(ej >= 0));
    chk({tag, " R6 upd"},     f, int'(ei >= 0 && ej >= ei));
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int widx_exp;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 r_wr in reset", r_wr, 0);
    @(negedge clk) rst = 0;
    adv_en = 1;
    #1;
    chk("R1 r_wr idle with adv_en", r_wr, 0);
    chk("R1 busy idle", busy, 0);
    adv_en = 0;

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    #1;
    chk("R2 busy", busy, 1);
    chk("R2 i start", i_idx, -1);
    chk("R2 j start", j_idx, 0);
    chk("R2 widx start", r_widx, 0);

    widx_exp = 0;
    for (int k = 0; k < N1; k++) begin
      if (k == 5) begin
        adv_en = 0;
        #1;
        chk("R8 no strobe on stall", r_wr, 0);
        @(negedge clk);
        #1;
        chk("R8 i held", i_idx, EXP_I[k]);
        chk("R8 j held", j_idx, EXP_J[k]);
      end
      adv_en = 1;
      start = (k == 7);
      #1;
      chk($sformatf("R3 R4 i step %0d", k), i_idx, EXP_I[k]);
      chk($sformatf("R3 R4 j step %0d", k), j_idx, EXP_J[k]);
      chk_flags($sformatf("step %0d", k), EXP_I[k], EXP_J[k], fa, fb, fc, fd, fe, ff);
      chk($sformatf("R7 strobe step %0d", k), r_wr,
          int'(EXP_J[k] >= EXP_I[k] + 1 && EXP_I[k] + 1 < 4));
      chk($sformatf("R7 widx step %0d", k), r_widx, widx_exp);
      chk($sformatf("R5 no early done %0d", k), done, 0);
      chk($sformatf("R9 busy step %0d", k), busy, 1);
      if (EXP_J[k] >= EXP_I[k] + 1 && EXP_I[k] + 1 < 4) widx_exp++;
      @(negedge clk);
      start = 0;
    end
    adv_en = 0;
    #1;
    chk("R5 done after total", done, 1);
    chk("R9 busy low at done", busy, 0);
    chk("R7 final widx", r_widx, 10);
    @(negedge clk);
    #1;
    chk("R9 done one cycle", done, 0);
    adv_en = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 stays idle", busy, 0);
    chk("R9 no strobe idle", r_wr, 0);
    adv_en = 0;

    begin
      int steps, wexp, jst;
      logic ok_seq;
      @(negedge clk) start2 = 1;
      @(negedge clk) start2 = 0;
      adv2 = 1;
      steps = 0;
      wexp = 0;
      ok_seq = 1;
      for (int ii = -1; ii < 4; ii++) begin
        jst = (ii == -1) ? 0 : (((4 - 6) > ii - 1) ? ii : (4 - 6));
        for (int jj = jst; jj < 4; jj++) begin
          #1;
          if (i2 != ii || j2 != jj) ok_seq = 0;
          if (r_wr2 != (jj >= ii + 1 && ii + 1 < 4)) ok_seq = 0;
          if (ge != (jj >= 0) || gf != (ii >= 0 && jj >= ii)) ok_seq = 0;
          if (ii == 0 && jj == -2) begin
            chk("R4 padded negative j", j2, -2);
            chk_flags("pad", ii, jj, ga, gb, gc, gd, ge, gf);
          end
          if (r_wr2) wexp++;
          steps++;
          @(negedge clk);
        end
      end
      adv2 = 0;
      #1;
      chk("R4 padded sequence matches", ok_seq, 1);
      chk("R5 padded total", steps, 28);
      chk("R5 padded done", done2, 1);
      chk("R7 padded widx", widx2, 10);
      chk("R7 padded strobes", wexp, 10);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule